// File: doc/BRIEF.md
# SPI Master with Receive-Mask Polling

This block is an 8-bit serial master. Each frame shifts one byte out on `mosi`, most significant bit first, and captures the byte the slave returns on `miso` in the same frame. Two control bits choose the idle level of the serial clock and the edge on which data is sampled. Together they give the four usual clock modes. The bit clock runs in one of two ways. In fast mode every system clock cycle is a half bit. In normal mode each pulse on an external timer input is a half bit, so the serial clock is that pulse stream divided by two.

The block has a receive-mask polling mode, used when waiting on a slave that reports "not ready" with a fixed byte. With this mode on, the master sends the byte held in its transmit buffer again and again, one frame after another. It stops at the first reply that differs from a programmed mask byte. While it repeats, no status flag moves and no interrupt is raised. Software sees one transaction: it writes once, and later the reply that differs appears in the receive buffer.

Three status flags are transmit-empty, receive-full and overrun. Each flag has its own interrupt enable. The control path is a small state machine with four states:
- `ST_IDLE`: waits for a transmit write (`ST_IDLE -> ST_LOAD`).
- `ST_LOAD`: loads the shifters for one frame (`ST_LOAD -> ST_LEAD`).
- `ST_LEAD`: waits for the tick that makes the leading clock edge (`ST_LEAD -> ST_TRAIL`).
- `ST_TRAIL`: waits for the tick that makes the trailing edge. From there it goes to `ST_TRAIL -> ST_LEAD` for the next bit. After the last bit it goes to `ST_TRAIL -> ST_LOAD` when the mask matches and the frame repeats, or to `ST_TRAIL -> ST_IDLE` when the frame ends.

Top module: `spi_mask_master`

## Requirements
- R1: After reset, the status register (address 4) reads 0x01. Its bits are bit0 transmit-empty, bit1 receive-full, bit2 overrun and bit3 busy. All three interrupt outputs are low and `sclk` is low.
- R2: A frame is 8 bits long. Writing address 0 sends that byte on `mosi`, MSB first. The byte received on `miso`, MSB first, is read back from address 1.
- R3: Control register (address 2) bit0 is the clock polarity and bit1 is the clock phase. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge. All four combinations transfer correctly.
- R4: A write to address 0 while busy is ignored. The frame in progress keeps the byte it started with, and address 0 still reads that earlier byte.
- R5: With control bit2 (fast) set, each clock cycle is one half bit and `timer_tick` has no effect. Receive-full becomes visible exactly 18 cycles after the edge that accepts the transmit write, and not before.
- R6: With bit2 clear, each `timer_tick` pulse is one half bit. No progress is made without pulses. A frame ends on exactly the 16th pulse.
- R7: With control bit3 (mask enable) set, a reply equal to the mask register (address 3) makes the same transmit byte go out again. The first reply that differs is stored at address 1 and ends the transaction.
- R8: While mask frames repeat, transmit-empty and receive-full stay clear and no interrupt is raised.
- R9: Receive-full is set when a received byte is stored. It is cleared by a read of address 1.
- R10: A byte that completes while receive-full is still set raises overrun and overwrites the buffer. Writing 1 to status bit2 clears overrun.
- R11: The interrupt enable register (address 5) has bit0 for transmit-empty, bit1 for receive-full and bit2 for overrun. Each bit gates only its own interrupt output.
- R12: While no frame is active, `sclk` rests at the polarity bit's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of the receive register clears receive-full |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| timer_tick | input | 1 | Half-bit pulse used in normal mode |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Overrun interrupt |

## Verification
The hardest case to reach from the ports is a run of mask repeats. The slave has to answer with the mask byte for several frames in a row and then with a different byte. During that whole run the flags and interrupts must stay hidden. The bench's slave model takes its replies from a queue, so one transmit write gives a chosen number of matching frames followed by a reply that differs. Status is polled every cycle of that run with all interrupts enabled. The normal-mode tick count is reached by driving single timer pulses by hand and checking busy just before and just after the 16th pulse.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_TXD  = 3'd0;
    localparam logic [REG_AW-1:0] A_RXD  = 3'd1;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd2;
    localparam logic [REG_AW-1:0] A_MASK = 3'd3;
    localparam logic [REG_AW-1:0] A_STAT = 3'd4;
    localparam logic [REG_AW-1:0] A_IEN  = 3'd5;

    // packed so that cpol is bit0, cpha bit1, fast bit2, mask_en bit3
    typedef struct packed {
        logic mask_en;
        logic fast;
        logic cpha;
        logic cpol;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_TRAIL
    } eng_state_t;

endpackage

// File: rtl/spi_mm_tick.sv
module spi_mm_tick (
    input  logic busy,
    input  logic fast,
    input  logic timer_tick,
    output logic half_tick
);

    // fast mode: every cycle is a half bit; normal mode: each timer pulse is
    always_comb begin
        half_tick = busy & (fast | timer_tick);
    end

endmodule

// File: rtl/spi_mm_regs.sv
module spi_mm_regs
    import spi_mm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              eng_busy,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_byte,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] mask_val,
    output logic [DATA_W-1:0] tx_byte,
    output logic              start,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);

    localparam int CFG_W = $bits(cfg_t);
    localparam int IE_W  = 3;

    cfg_t              ctrl_q;
    logic [DATA_W-1:0] mask_q;
    logic [IE_W-1:0]   ie_q;
    logic [DATA_W-1:0] txbuf_q;
    logic [DATA_W-1:0] rxbuf_q;
    logic              txe_q;
    logic              rxf_q;
    logic              ovr_q;

    logic wr_tx, wr_ctrl, wr_mask, wr_stat, wr_ie, rd_rx;

    always_comb begin
        wr_tx   = wr_en && (addr == A_TXD);
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_mask = wr_en && (addr == A_MASK);
        wr_stat = wr_en && (addr == A_STAT);
        wr_ie   = wr_en && (addr == A_IEN);
        rd_rx   = rd_en && (addr == A_RXD);
        start   = wr_tx && !eng_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mask_q  <= '0;
            ie_q    <= '0;
            txbuf_q <= '0;
            rxbuf_q <= '0;
            txe_q   <= 1'b1;
            rxf_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= cfg_t'(wdata[CFG_W-1:0]);
            if (wr_mask) mask_q <= wdata;
            if (wr_ie)   ie_q   <= wdata[IE_W-1:0];

            if (frame_done) begin
                rxbuf_q <= frame_byte;
                txe_q   <= 1'b1;
            end
            if (start) begin
                txbuf_q <= wdata;
                txe_q   <= 1'b0;
            end

            if (frame_done)  rxf_q <= 1'b1;
            else if (rd_rx)  rxf_q <= 1'b0;

            if (frame_done && rxf_q && !rd_rx) ovr_q <= 1'b1;
            else if (wr_stat && wdata[2])      ovr_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_TXD:   rdata = txbuf_q;
            A_RXD:   rdata = rxbuf_q;
            A_CTRL:  rdata[CFG_W-1:0] = ctrl_q;
            A_MASK:  rdata = mask_q;
            A_STAT:  rdata[3:0] = {eng_busy, ovr_q, rxf_q, txe_q};
            A_IEN:   rdata[IE_W-1:0] = ie_q;
            default: rdata = '0;
        endcase
    end

    always_comb begin
        cfg      = ctrl_q;
        mask_val = mask_q;
        tx_byte  = txbuf_q;
        tx_empty = txe_q;
        rx_full  = rxf_q;
        overrun  = ovr_q;
        irq_tx   = ie_q[0] & txe_q;
        irq_rx   = ie_q[1] & rxf_q;
        irq_err  = ie_q[2] & ovr_q;
    end

endmodule

// File: rtl/spi_mm_engine.sv
module spi_mm_engine
    import spi_mm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              mask_en,
    input  logic [DATA_W-1:0] mask_val,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              start,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_byte
);

    localparam int                CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);

    eng_state_t        state_q, state_d;
    logic [DATA_W-1:0] txsh_q;
    logic [DATA_W-1:0] rxsh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              phase_q;
    logic              mosi_q;
    logic              done_q;
    logic [DATA_W-1:0] done_byte_q;

    logic [DATA_W-1:0] rx_next;
    logic              last_bit;
    logic              repeat_hit;

    always_comb begin
        rx_next    = cpha ? {rxsh_q[DATA_W-2:0], miso} : rxsh_q;
        last_bit   = (cnt_q == LAST);
        repeat_hit = mask_en && (rx_next == mask_val);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_TRAIL;
            ST_TRAIL: begin
                if (tick) begin
                    if (!last_bit)       state_d = ST_LEAD;
                    else if (repeat_hit) state_d = ST_LOAD;
                    else                 state_d = ST_IDLE;
                end
            end
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txsh_q      <= '0;
            rxsh_q      <= '0;
            cnt_q       <= '0;
            phase_q     <= 1'b0;
            mosi_q      <= 1'b0;
            done_q      <= 1'b0;
            done_byte_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    phase_q <= 1'b0;
                end
                ST_LOAD: begin
                    cnt_q   <= '0;
                    phase_q <= 1'b0;
                    rxsh_q  <= '0;
                    if (!cpha) begin
                        mosi_q <= tx_byte[DATA_W-1];
                        txsh_q <= {tx_byte[DATA_W-2:0], 1'b0};
                    end else begin
                        txsh_q <= tx_byte;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        phase_q <= 1'b1;
                        if (!cpha) begin
                            rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
                        end else begin
                            mosi_q <= txsh_q[DATA_W-1];
                            txsh_q <= {txsh_q[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        phase_q <= 1'b0;
                        rxsh_q  <= rx_next;
                        if (!last_bit) begin
                            cnt_q <= cnt_q + 1'b1;
                            if (!cpha) begin
                                mosi_q <= txsh_q[DATA_W-1];
                                txsh_q <= {txsh_q[DATA_W-2:0], 1'b0};
                            end
                        end else if (!repeat_hit) begin
                            done_q      <= 1'b1;
                            done_byte_q <= rx_next;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        sclk       = cpol ^ phase_q;
        mosi       = mosi_q;
        busy       = (state_q != ST_IDLE);
        frame_done = done_q;
        frame_byte = done_byte_q;
    end

endmodule

// File: rtl/spi_mask_master.sv
module spi_mask_master
    import spi_mm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              timer_tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);

    cfg_t              cfg;
    logic [DATA_W-1:0] mask_val;
    logic [DATA_W-1:0] tx_byte;
    logic              start;
    logic              eng_busy;
    logic              frame_done;
    logic [DATA_W-1:0] frame_byte;
    logic              half_tick;
    logic              tx_empty;
    logic              rx_full;
    logic              overrun;

    spi_mm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .eng_busy   (eng_busy),
        .frame_done (frame_done),
        .frame_byte (frame_byte),
        .cfg        (cfg),
        .mask_val   (mask_val),
        .tx_byte    (tx_byte),
        .start      (start),
        .tx_empty   (tx_empty),
        .rx_full    (rx_full),
        .overrun    (overrun),
        .irq_tx     (irq_tx),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err)
    );

    spi_mm_tick u_tick (
        .busy       (eng_busy),
        .fast       (cfg.fast),
        .timer_tick (timer_tick),
        .half_tick  (half_tick)
    );

    spi_mm_engine #(.DATA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpol       (cfg.cpol),
        .cpha       (cfg.cpha),
        .mask_en    (cfg.mask_en),
        .mask_val   (mask_val),
        .tx_byte    (tx_byte),
        .start      (start),
        .tick       (half_tick),
        .miso       (miso),
        .sclk       (sclk),
        .mosi       (mosi),
        .busy       (eng_busy),
        .frame_done (frame_done),
        .frame_byte (frame_byte)
    );

endmodule

// File: rtl/spi_mm_checker.sv
module spi_mm_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic cpol,
    input logic sclk,
    input logic tick,
    input logic tx_empty,
    input logic rx_full,
    input logic overrun,
    input logic done
);

    // R12: serial clock rests at the polarity level when no frame runs
    a_r12_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    // R8: transmit-empty never reappears while the engine is working
    a_r8_no_txe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_empty);

    // R9: receive-full only rises after the engine hands over a byte
    a_r9_rxf_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(done));

    // R10: overrun only rises when a byte lands on an unread buffer
    a_r10_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(done) && $past(rx_full)));

    // R5: the serial clock only moves on a half-bit tick
    a_r5_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sclk) && $stable(cpol)) |-> $past(tick));

endmodule

bind spi_mask_master spi_mm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (eng_busy),
    .cpol     (cfg.cpol),
    .sclk     (sclk),
    .tick     (half_tick),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .overrun  (overrun),
    .done     (frame_done)
);

// File: tb/spi_mask_master_test.sv
module spi_mask_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       timer_tick = 1'b0;
    logic       miso = 1'b0;
    logic       sclk, mosi, irq_tx, irq_rx, irq_err;

    always #4 clk = ~clk;

    spi_mask_master uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .timer_tick(timer_tick), .miso(miso), .sclk(sclk), .mosi(mosi),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard queues and slave model
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rep_q[$];
    logic       s_cpol = 1'b0;
    logic       s_cpha = 1'b0;
    int         s_cnt = 0;
    logic [7:0] s_cur = 8'h00;
    logic [7:0] s_rcv = 8'h00;
    logic       noise_on = 1'b0;

    task automatic load_next();
        if (rep_q.size() > 0) s_cur = rep_q.pop_front();
        else                  s_cur = 8'h00;
        if (!s_cpha) miso = s_cur[7];
    endtask

    task automatic frame_end();
        if (exp_q.size() == 0) begin
            chk("R2 unexpected frame", {24'h0, s_rcv}, 32'hFFFF_FFFF);
        end else begin
            chk(tag_q.pop_front(), {24'h0, s_rcv}, {24'h0, exp_q.pop_front()});
        end
        s_cnt = 0;
        load_next();
    endtask

    // monitor: follows sclk edges, pops and compares finished frames
    always @(sclk) begin
        if (rst_n) begin
            if (sclk !== s_cpol) begin
                if (!s_cpha) begin
                    s_rcv = {s_rcv[6:0], mosi};
                    s_cnt++;
                end else if (s_cnt < 8) begin
                    miso = s_cur[3'(7 - s_cnt)];
                end
            end else begin
                if (!s_cpha) begin
                    if (s_cnt == 8) frame_end();
                    else if (s_cnt > 0) miso = s_cur[3'(7 - s_cnt)];
                end else begin
                    s_rcv = {s_rcv[6:0], mosi};
                    s_cnt++;
                    if (s_cnt == 8) frame_end();
                end
            end
        end
    end

    always @(negedge clk) if (noise_on) timer_tick = ~timer_tick;

    task automatic reg_wr(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_ctrl(logic [7:0] v);
        reg_wr(3'd2, v);
        s_cpol = v[0];
        s_cpha = v[1];
        repeat (2) @(negedge clk);
        s_cnt = 0;
        s_rcv = 8'h00;
    endtask

    // driver: expected frame and slave reply go into the queues
    task automatic push_frame(logic [7:0] tx, logic [7:0] reply, string tag);
        exp_q.push_back(tx);
        tag_q.push_back(tag);
        rep_q.push_back(reply);
    endtask

    task automatic launch(logic [7:0] tx);
        load_next();
        reg_wr(3'd0, tx);
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        int guard = 0;
        do begin
            reg_rd(3'd4, st);
            guard++;
        end while (st[3] && guard < 5000);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_tick();
        timer_tick = 1'b1;
        @(negedge clk);
        timer_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] st;
        logic [7:0] d;
        int bad;
        int guard;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_rd(3'd4, st);
        chk("R1 status", {24'h0, st}, 32'h01);
        chk("R1 irqs", {29'h0, irq_tx, irq_rx, irq_err}, 32'h0);
        chk("R1 sclk", {31'h0, sclk}, 32'h0);

        // R2 / R5: mode 0, fast, timer noise running
        set_ctrl(8'h04);
        noise_on = 1'b1;
        push_frame(8'hA5, 8'h3C, "R2 mode0 mosi");
        launch(8'hA5);
        wait_idle();
        reg_rd(3'd4, st);
        chk("R9 rx_full set", {31'h0, st[1]}, 32'h1);
        reg_rd(3'd1, d);
        chk("R2 rx byte", {24'h0, d}, 32'h3C);
        reg_rd(3'd4, st);
        chk("R9 rx_full cleared", {31'h0, st[1]}, 32'h0);

        // R5: exact completion time in fast mode
        push_frame(8'h96, 8'h69, "R5 mosi");
        load_next();
        reg_wr(3'd0, 8'h96);
        repeat (17) @(negedge clk);
        addr = 3'd4;
        #1 chk("R5 not yet full", {31'h0, rdata[1]}, 32'h0);
        @(negedge clk);
        #1 chk("R5 full on time", {31'h0, rdata[1]}, 32'h1);
        @(negedge clk);
        reg_rd(3'd1, d);
        chk("R5 rx byte", {24'h0, d}, 32'h69);

        // R3 / R12: remaining clock modes
        for (int m = 1; m < 4; m++) begin
            set_ctrl(8'h04 | 8'(m));
            chk("R12 idle level", {31'h0, sclk}, {31'h0, m[0]});
            push_frame(8'(8'h5C + m), 8'(8'hC1 ^ (m * 8'h11)), "R3 mode mosi");
            launch(8'(8'h5C + m));
            wait_idle();
            reg_rd(3'd1, d);
            chk("R3 mode rx", {24'h0, d}, {24'h0, 8'(8'hC1 ^ (m * 8'h11))});
            chk("R12 idle after frame", {31'h0, sclk}, {31'h0, m[0]});
        end

        // R4: busy write ignored
        set_ctrl(8'h04);
        push_frame(8'h81, 8'h18, "R4 mosi kept");
        launch(8'h81);
        reg_wr(3'd0, 8'h7E);
        wait_idle();
        reg_rd(3'd0, d);
        chk("R4 tx readback", {24'h0, d}, 32'h81);
        reg_rd(3'd1, d);
        chk("R4 rx", {24'h0, d}, 32'h18);

        // R10 / R11: overrun and interrupt gating
        push_frame(8'h11, 8'h22, "R10 first mosi");
        launch(8'h11);
        wait_idle();
        push_frame(8'h33, 8'h44, "R10 second mosi");
        launch(8'h33);
        wait_idle();
        reg_rd(3'd4, st);
        chk("R10 overrun status", {24'h0, st}, 32'h07);
        reg_wr(3'd5, 8'h01);
        #1 chk("R11 tx only", {29'h0, irq_tx, irq_rx, irq_err}, 32'h4);
        reg_wr(3'd5, 8'h02);
        #1 chk("R11 rx only", {29'h0, irq_tx, irq_rx, irq_err}, 32'h2);
        reg_wr(3'd5, 8'h04);
        #1 chk("R11 err only", {29'h0, irq_tx, irq_rx, irq_err}, 32'h1);
        reg_wr(3'd5, 8'h00);
        #1 chk("R11 none", {29'h0, irq_tx, irq_rx, irq_err}, 32'h0);
        reg_rd(3'd1, d);
        chk("R10 overwritten", {24'h0, d}, 32'h44);
        reg_wr(3'd4, 8'h04);
        reg_rd(3'd4, st);
        chk("R10 cleared", {24'h0, st}, 32'h01);

        // R7 / R8: mask polling with two matching replies
        reg_wr(3'd5, 8'h07);
        reg_wr(3'd3, 8'hFF);
        set_ctrl(8'h0C);
        push_frame(8'h5A, 8'hFF, "R7 repeat 1");
        push_frame(8'h5A, 8'hFF, "R7 repeat 2");
        push_frame(8'h5A, 8'hC3, "R7 final");
        launch(8'h5A);
        bad = 0;
        guard = 0;
        do begin
            reg_rd(3'd4, st);
            if (st[3] && (st[0] || st[1] || irq_tx || irq_rx || irq_err)) bad++;
            guard++;
        end while (st[3] && guard < 5000);
        chk("R8 hidden flags", bad, 0);
        repeat (2) @(negedge clk);
        chk("R7 all frames", exp_q.size(), 0);
        reg_rd(3'd1, d);
        chk("R7 stored reply", {24'h0, d}, 32'hC3);

        // R7: first reply already differs
        push_frame(8'h24, 8'h00, "R7 single");
        launch(8'h24);
        wait_idle();
        reg_rd(3'd1, d);
        chk("R7 single rx", {24'h0, d}, 32'h00);
        reg_wr(3'd5, 8'h00);

        // R6: normal mode, manual timer pulses
        noise_on = 1'b0;
        timer_tick = 1'b0;
        set_ctrl(8'h00);
        push_frame(8'hC6, 8'h6C, "R6 mosi");
        launch(8'hC6);
        repeat (8) @(negedge clk);
        reg_rd(3'd4, st);
        chk("R6 stalls busy", {31'h0, st[3]}, 32'h1);
        chk("R6 sclk still", {31'h0, sclk}, 32'h0);
        for (int t = 0; t < 15; t++) pulse_tick();
        reg_rd(3'd4, st);
        chk("R6 busy at 15", {31'h0, st[3]}, 32'h1);
        pulse_tick();
        reg_rd(3'd4, st);
        chk("R6 done at 16", {28'h0, st[3:0]}, 32'h3);
        reg_rd(3'd1, d);
        chk("R6 rx", {24'h0, d}, 32'h6C);

        chk("R2 no pending frames", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule